// File: doc/BRIEF.md
# Binary32 Truncating Multiplier

This block takes two single-precision binary floating-point operands and returns their product in the same 32-bit format. Each value has a sign bit (bit 31), an 8-bit biased exponent (bits 30:23, bias 127) and a 23-bit fraction (bits 22:0). The sign, exponent and significand are processed along separate paths. The two biased exponents are summed by a small carry-select adder. In that adder the upper half's carry-in-one result is formed by an increment stage rather than a second adder. The sum is then corrected for the bias and for normalization of the 48-bit significand product.

Only normal numbers and zero take part in arithmetic. An operand with exponent field 0 is treated as zero, so denormals are flushed. Infinities and NaNs follow fixed propagation rules. Results are truncated toward zero. A product that leaves the normal exponent range raises an overflow or underflow flag. Each accepted operand pair produces a registered result one clock later.

Top module: `fp32_mul_trunc`

## Requirements
- R1: For every result that is not a NaN, result bit 31 equals the XOR of the two operand sign bits.
- R2: For two normal operands whose significand product is below 2, the result exponent is Ea + Eb - 127. The fraction is product bits 45:23, truncated.
- R3: When the significand product is 2 or more (product bit 47 set), the fraction is product bits 46:24 and the exponent is Ea + Eb - 126. This can bring an exponent that would otherwise be 0 back into range.
- R4: For normal operands whose adjusted exponent is 255 or more, the result is signed infinity (exponent 0xFF, fraction 0) and overflow is 1.
- R5: For normal operands whose adjusted exponent is 0 or less, the result is signed zero and underflow is 1.
- R6: An operand with exponent field 0 (zero or denormal) times a normal or zero operand gives signed zero, with both flags 0.
- R7: Infinity times a normal or infinite operand gives signed infinity, with both flags 0.
- R8: Infinity times an operand with exponent field 0 gives 0x7FC00000, with both flags 0.
- R9: If op_a is a NaN (exponent 0xFF, fraction nonzero), the result is op_a with bit 22 forced to 1. Otherwise, if op_b is a NaN, the result is op_b with bit 22 forced to 1. Both flags are 0 in either case.
- R10: The result and flags are registered when in_valid is 1. out_valid is 1 exactly in the cycle after an in_valid cycle. When in_valid is 0, the result and flags hold their values.
- R11: While reset is asserted, and after its release, result, overflow, underflow and out_valid are 0 until the first accepted operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operands are valid and are captured this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result is from the previous cycle's operands |
| result | output | 32 | Binary32 product |
| overflow | output | 1 | Product exponent exceeded the normal range |
| underflow | output | 1 | Product exponent fell below the normal range |

## Verification
The block keeps no state between operations beyond the output register, so any internal error shows up in the very next result. A wrong carry select in the exponent adder shifts the result exponent by a power of 16. A missed normalization shift halves the value and misaligns the fraction. Both are caught by operand pairs on each side of the product-equals-2 boundary. A misplaced range comparison shows as a wrong flag or a wrong special value at exactly the exponent 0, 1, 254 and 255 edges, which the directed pairs hit head-on.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef enum logic [1:0] {
    OPK_ZERO = 2'd0,
    OPK_NORM = 2'd1,
    OPK_INF  = 2'd2,
    OPK_NAN  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpm_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW-1:0] exp_i,
  input  logic [FW-1:0] frac_i,
  output op_kind_e      kind_o
);
  logic exp_zero, exp_ones, frac_zero;

  always_comb begin
    exp_zero  = (exp_i == '0);
    exp_ones  = (exp_i == '1);
    frac_zero = (frac_i == '0);
    if (exp_zero)       kind_o = OPK_ZERO;
    else if (!exp_ones) kind_o = OPK_NORM;
    else if (frac_zero) kind_o = OPK_INF;
    else                kind_o = OPK_NAN;
  end
endmodule

// File: rtl/fpm_exp_adder.sv
module fpm_exp_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   sum_o
);
  localparam int LO = W / 2;
  localparam int HI = W - LO;

  logic [LO:0]   lo_sum;
  logic [HI:0]   hi_c0;
  logic [HI:0]   hi_c1;
  logic [HI:0]   run_and;

  assign lo_sum = {1'b0, a_i[LO-1:0]} + {1'b0, b_i[LO-1:0]};
  assign hi_c0  = {1'b0, a_i[W-1:LO]} + {1'b0, b_i[W-1:LO]};

  // increment stage: bit i flips when all lower bits are one
  assign run_and[0] = 1'b1;
  assign hi_c1[0]   = ~hi_c0[0];
  for (genvar i = 1; i <= HI; i++) begin : g_inc
    assign run_and[i] = run_and[i-1] & hi_c0[i-1];
    assign hi_c1[i]   = hi_c0[i] ^ run_and[i];
  end

  assign sum_o = {(lo_sum[LO] ? hi_c1 : hi_c0), lo_sum[LO-1:0]};
endmodule

// File: rtl/fpm_sig_mul.sv
module fpm_sig_mul #(
  parameter int FW = 23
) (
  input  logic [FW-1:0] frac_a_i,
  input  logic [FW-1:0] frac_b_i,
  output logic          norm_o,
  output logic [FW-1:0] frac_o
);
  localparam int SW = FW + 1;
  localparam int PW = 2 * SW;

  logic [PW-1:0] prod;

  assign prod   = {{SW{1'b0}}, 1'b1, frac_a_i} * {{SW{1'b0}}, 1'b1, frac_b_i};
  assign norm_o = prod[PW-1];
  assign frac_o = norm_o ? prod[PW-2 -: FW] : prod[PW-3 -: FW];
endmodule

// File: rtl/fp32_mul_trunc.sv
module fp32_mul_trunc
  import fpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        overflow,
  output logic        underflow
);
  localparam int AW = EXP_W + 2;
  localparam logic [AW-1:0] EXP_MAX = AW'((1 << EXP_W) - 1);
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // field split
  logic              sgn_a, sgn_b, sgn_p;
  logic [EXP_W-1:0]  exp_a, exp_b;
  logic [FRAC_W-1:0] frc_a, frc_b;
  op_kind_e          kind_a, kind_b;

  assign {sgn_a, exp_a, frc_a} = op_a;
  assign {sgn_b, exp_b, frc_b} = op_b;
  assign sgn_p = sgn_a ^ sgn_b;

  fpm_classify #(.EW(EXP_W), .FW(FRAC_W)) u_cls_a (
    .exp_i(exp_a), .frac_i(frc_a), .kind_o(kind_a)
  );
  fpm_classify #(.EW(EXP_W), .FW(FRAC_W)) u_cls_b (
    .exp_i(exp_b), .frac_i(frc_b), .kind_o(kind_b)
  );

  // exponent path
  logic [EXP_W:0] exp_sum;

  fpm_exp_adder #(.W(EXP_W)) u_exp_add (
    .a_i(exp_a), .b_i(exp_b), .sum_o(exp_sum)
  );

  // significand path
  logic              prod_norm;
  logic [FRAC_W-1:0] prod_frac;

  fpm_sig_mul #(.FW(FRAC_W)) u_sig_mul (
    .frac_a_i(frc_a), .frac_b_i(frc_b), .norm_o(prod_norm), .frac_o(prod_frac)
  );

  // bias and normalization correction, signed in AW bits
  logic [AW-1:0] exp_adj;
  logic          adj_low, adj_high;

  assign exp_adj  = {1'b0, exp_sum} + AW'(prod_norm) - AW'(BIAS);
  assign adj_low  = exp_adj[AW-1] || (exp_adj == '0);
  assign adj_high = !exp_adj[AW-1] && (exp_adj >= EXP_MAX);

  // result selection
  logic [WORD_W-1:0] res_nxt;
  logic              ovf_nxt, unf_nxt;

  always_comb begin
    res_nxt = '0;
    ovf_nxt = 1'b0;
    unf_nxt = 1'b0;
    if (kind_a == OPK_NAN) begin
      res_nxt = op_a | (WORD_W'(1) << (FRAC_W - 1));
    end else if (kind_b == OPK_NAN) begin
      res_nxt = op_b | (WORD_W'(1) << (FRAC_W - 1));
    end else if ((kind_a == OPK_INF && kind_b == OPK_ZERO) ||
                 (kind_a == OPK_ZERO && kind_b == OPK_INF)) begin
      res_nxt = QNAN;
    end else if (kind_a == OPK_INF || kind_b == OPK_INF) begin
      res_nxt = {sgn_p, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (kind_a == OPK_ZERO || kind_b == OPK_ZERO) begin
      res_nxt = {sgn_p, {(WORD_W-1){1'b0}}};
    end else if (adj_high) begin
      res_nxt = {sgn_p, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf_nxt = 1'b1;
    end else if (adj_low) begin
      res_nxt = {sgn_p, {(WORD_W-1){1'b0}}};
      unf_nxt = 1'b1;
    end else begin
      res_nxt = {sgn_p, exp_adj[EXP_W-1:0], prod_frac};
    end
  end

  // output register with explicit enable
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_nxt;
        overflow  <= ovf_nxt;
        underflow <= unf_nxt;
      end
    end
  end
endmodule

// File: rtl/fp32_mul_trunc_chk.sv
module fp32_mul_trunc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        overflow,
  input logic        underflow
);
  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(overflow) && $stable(underflow)));

  // R4
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result[30:0] == 31'h7F800000));

  // R5
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (result[30:0] == 31'h0));

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && underflow));

  // R1
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(result[30:23] == 8'hFF && result[22:0] != 23'h0))
      |-> (result[31] == ($past(op_a[31]) ^ $past(op_b[31]))));
endmodule

bind fp32_mul_trunc fp32_mul_trunc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .result(result), .overflow(overflow), .underflow(underflow)
);

// File: tb/test_fp32_mul_trunc.sv
`timescale 1ns/1ps
module test_fp32_mul_trunc;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [31:0] result;
  logic        overflow, underflow;

  int n_chk;
  int n_bad;
  bit finished;

  fp32_mul_trunc i_fp32_mul_trunc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .overflow(overflow), .underflow(underflow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h ({valid,ovf,unf,result})", req, act, exp);
    end
  endtask

  // one operand pair; sample at the falling edge after the capturing edge
  task automatic mul(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] exp_res, input logic exp_ovf, input logic exp_unf);
    @(negedge clk);
    op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, overflow, underflow, result}, {1'b1, exp_ovf, exp_unf, exp_res});
  endtask

  task automatic t_reset;
    check("R11", {out_valid, overflow, underflow, result}, 35'h0);
  endtask

  task automatic t_normal;
    mul("R2", 32'h40000000, 32'h40400000, 32'h40C00000, 0, 0);  // 2*3
    mul("R2", 32'h3F800001, 32'h3FC00000, 32'h3FC00001, 0, 0);  // truncation
    mul("R2", 32'h00800000, 32'h3F800000, 32'h00800000, 0, 0);  // smallest normal kept
    mul("R2", 32'h7F000000, 32'h3F800000, 32'h7F000000, 0, 0);  // largest exponent kept
  endtask

  task automatic t_sign;
    mul("R1", 32'hC0000000, 32'h40400000, 32'hC0C00000, 0, 0);
    mul("R1", 32'hC0000000, 32'hC0400000, 32'h40C00000, 0, 0);
  endtask

  task automatic t_norm;
    mul("R3", 32'h3FC00000, 32'h3FC00000, 32'h40100000, 0, 0);  // 1.5*1.5
    mul("R3", 32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 0, 0);
    mul("R3", 32'h00C00000, 32'h3F400000, 32'h00900000, 0, 0);  // rescued from exp 0
  endtask

  task automatic t_range;
    mul("R4", 32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0);
    mul("R4", 32'hFF000000, 32'h40000000, 32'hFF800000, 1, 0);
    mul("R5", 32'h00800000, 32'h3F000000, 32'h00000000, 0, 1);
    mul("R5", 32'h80800000, 32'h3F000000, 32'h80000000, 0, 1);
  endtask

  task automatic t_special;
    mul("R6", 32'h00000000, 32'hC0000000, 32'h80000000, 0, 0);
    mul("R6", 32'h00000001, 32'h40000000, 32'h00000000, 0, 0);
    mul("R7", 32'h7F800000, 32'hC0000000, 32'hFF800000, 0, 0);
    mul("R7", 32'hFF800000, 32'hFF800000, 32'h7F800000, 0, 0);
    mul("R8", 32'h7F800000, 32'h00000005, 32'h7FC00000, 0, 0);
    mul("R8", 32'h80000000, 32'hFF800000, 32'h7FC00000, 0, 0);
    mul("R9", 32'h7F800001, 32'h3F800000, 32'h7FC00001, 0, 0);
    mul("R9", 32'h7F800000, 32'hFFC00002, 32'hFFC00002, 0, 0);
    mul("R9", 32'hFF800003, 32'h7FC00004, 32'hFFC00003, 0, 0);
  endtask

  task automatic t_hold;
    mul("R10", 32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0);
    @(negedge clk);
    op_a = 32'h3F800000; op_b = 32'h3F800000;
    @(negedge clk);
    check("R10", {out_valid, overflow, underflow, result}, {1'b0, 1'b1, 1'b0, 32'h7F800000});
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_normal();
    t_sign();
    t_norm();
    t_range();
    t_special();
    t_hold();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule